// File: doc/BRIEF.md
# FSK Identifier Tag Waveform Generator

This block produces the load-modulation stream that a low-frequency tag uses to send a 44-bit identifier to a reader. Every clock is one carrier tick, and each tick yields one output bit. When the bit is 1 the coil switch is opened, and when it is 0 the coil is shorted. The stream is built from two carrier-derived patterns. The "fast" pattern repeats every 8 ticks and the "slow" pattern repeats every 10 ticks. One Manchester half-bit is a burst of one of these patterns, about 50 ticks long.

A frame begins with a fixed start marker made of half-bit pairs that are not valid Manchester pairs. The identifier follows with its most significant bit first. A one-period fast separator is placed in front of each group of four identifier bits. While `enable` is high, the frame repeats back to back with no gap.

The identifier is captured on the first tick of every frame, so changing `tag_id` during a frame only affects the next frame. The output runs freely, one bit per tick. It has no valid/ready handshake, and the consumer cannot apply back-pressure, because the coil must follow the carrier without pause.

Top module: `fsk_tag_wavegen`

## Requirements
- R1: While `enable` is low, `coil_out` and `frame_start` are both 0.
- R2: A fast half-bit lasts 48 ticks. It is 6 repetitions of the 8-tick pattern 11000000, so it holds 12 ones.
- R3: A slow half-bit lasts 50 ticks. It is 5 repetitions of the 10-tick pattern 1110000000, so it holds 15 ones. No run of ones in the stream is longer than 3 ticks.
- R4: Each frame opens with a 392-tick marker made of these half-bits in order: fast, fast, fast, slow, slow, slow, fast, slow.
- R5: After the marker, the identifier bits are sent from bit 43 down to bit 0. A 1 is a fast half-bit then a slow half-bit. A 0 is a slow half-bit then a fast half-bit.
- R6: An 8-tick separator 11000000 is sent just before every identifier bit whose index modulo 4 equals 3 (43, 39, ..., 3).
- R7: A frame is 4792 ticks long. While enabled, the next frame starts on the very next tick after the last one.
- R8: `frame_start` is high for exactly one tick: the first tick of each marker. The first tick with `enable` high is always such a tick.
- R9: `tag_id` is sampled on the first tick of a frame. A change to it later in the frame does not alter that frame's data.
- R10: If `enable` drops in the middle of a frame and is later raised again, transmission restarts at tick 0 of the marker.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Carrier tick clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Run the generator; low holds it idle at the frame head |
| tag_id | input | 44 | Identifier to transmit, sampled at frame start |
| coil_out | output | 1 | 1 opens the coil, 0 shorts it |
| frame_start | output | 1 | One-tick pulse on the first tick of each frame |

## Verification
The assertions check several properties on every cycle:
- the idle output while disabled;
- the frame pulse on the first enabled tick;
- the exact 4792-tick spacing between frame pulses;
- a rising-edge spacing of 8 or 10 ticks;
- a maximum high run of 3.

Other behaviour only the bench's scenarios can show, by comparing every tick against an arithmetic model of the frame. This covers the order of marker half-bits, the bit-to-half-bit mapping, where the separators fall, the capture of the identifier at frame start, and the restart after a mid-frame disable.

// File: rtl/fsk_wave_pkg.sv
package fsk_wave_pkg;

  typedef enum logic [1:0] {
    ST_MARK = 2'd0,
    ST_SEP  = 2'd1,
    ST_DATA = 2'd2
  } stage_e;

  // One burst segment: pattern choice and whether it is a short separator.
  typedef struct packed {
    logic slow;
    logic short_seg;
  } seg_t;

endpackage

// File: rtl/fsk_burst.sv
// Pattern unit: walks the periods of one segment and reports its last tick.
module fsk_burst
  import fsk_wave_pkg::*;
#(
  parameter int FAST_DIV  = 8,
  parameter int FAST_HIGH = 2,
  parameter int FAST_REPS = 6,
  parameter int SLOW_DIV  = 10,
  parameter int SLOW_HIGH = 3,
  parameter int SLOW_REPS = 5,
  parameter int SEP_REPS  = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  seg_t seg,
  output logic level,
  output logic seg_first,
  output logic seg_last
);

  localparam int MAX_DIV  = (SLOW_DIV > FAST_DIV) ? SLOW_DIV : FAST_DIV;
  localparam int PW       = $clog2(MAX_DIV);
  localparam int MAX_R0   = (SLOW_REPS > FAST_REPS) ? SLOW_REPS : FAST_REPS;
  localparam int MAX_REPS = (SEP_REPS > MAX_R0) ? SEP_REPS : MAX_R0;
  localparam int RW       = (MAX_REPS > 1) ? $clog2(MAX_REPS) : 1;

  logic [PW-1:0] phase_q;
  logic [RW-1:0] rep_q;
  logic [PW-1:0] div_m1;
  logic [PW-1:0] high_n;
  logic [RW-1:0] reps_m1;
  logic          period_end;

  always_comb begin
    div_m1 = seg.slow ? PW'(SLOW_DIV - 1) : PW'(FAST_DIV - 1);
    high_n = seg.slow ? PW'(SLOW_HIGH) : PW'(FAST_HIGH);
    if (seg.short_seg)
      reps_m1 = RW'(SEP_REPS - 1);
    else
      reps_m1 = seg.slow ? RW'(SLOW_REPS - 1) : RW'(FAST_REPS - 1);
  end

  assign period_end = (phase_q == div_m1);
  assign seg_last   = period_end && (rep_q == reps_m1);
  assign seg_first  = (phase_q == '0) && (rep_q == '0);
  assign level      = (phase_q < high_n);

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      phase_q <= '0;
      rep_q   <= '0;
    end else if (period_end) begin
      phase_q <= '0;
      rep_q   <= seg_last ? '0 : rep_q + RW'(1);
    end else begin
      phase_q <= phase_q + PW'(1);
    end
  end

endmodule

// File: rtl/fsk_frame_seq.sv
// Frame sequencer: marker half-bits, separators and Manchester data halves.
module fsk_frame_seq
  import fsk_wave_pkg::*;
#(
  parameter int                  ID_BITS  = 44,
  parameter int                  GROUP    = 4,
  parameter int                  MARK_LEN = 8,
  parameter logic [MARK_LEN-1:0] MARK_PAT = 8'b1011_1000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic               seg_last,
  input  logic [ID_BITS-1:0] id_bits,
  output seg_t               seg,
  output logic               at_head
);

  localparam int BW = $clog2(ID_BITS);
  localparam int MW = (MARK_LEN > 1) ? $clog2(MARK_LEN) : 1;

  stage_e        stage_q;
  logic [MW-1:0] mark_q;
  logic [BW-1:0] bit_q;
  logic          half_q;

  function automatic stage_e entry_for(input logic [BW-1:0] idx);
    return ((int'(idx) % GROUP) == (GROUP - 1)) ? ST_SEP : ST_DATA;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n || !run) begin
      stage_q <= ST_MARK;
      mark_q  <= '0;
      bit_q   <= BW'(ID_BITS - 1);
      half_q  <= 1'b0;
    end else if (seg_last) begin
      case (stage_q)
        ST_MARK: begin
          if (mark_q == MW'(MARK_LEN - 1)) begin
            mark_q  <= '0;
            bit_q   <= BW'(ID_BITS - 1);
            half_q  <= 1'b0;
            stage_q <= entry_for(BW'(ID_BITS - 1));
          end else begin
            mark_q <= mark_q + MW'(1);
          end
        end
        ST_SEP: begin
          stage_q <= ST_DATA;
          half_q  <= 1'b0;
        end
        ST_DATA: begin
          if (!half_q) begin
            half_q <= 1'b1;
          end else begin
            half_q <= 1'b0;
            if (bit_q == '0) begin
              stage_q <= ST_MARK;
              mark_q  <= '0;
            end else begin
              bit_q   <= bit_q - BW'(1);
              stage_q <= entry_for(bit_q - BW'(1));
            end
          end
        end
        default: stage_q <= ST_MARK;
      endcase
    end
  end

  always_comb begin
    seg = '0;
    case (stage_q)
      ST_MARK: seg.slow = MARK_PAT[mark_q];
      ST_SEP:  seg.short_seg = 1'b1;
      ST_DATA: seg.slow = ~(id_bits[bit_q] ^ half_q);
      default: seg = '0;
    endcase
  end

  assign at_head = (stage_q == ST_MARK) && (mark_q == '0);

endmodule

// File: rtl/fsk_tag_wavegen.sv
module fsk_tag_wavegen
  import fsk_wave_pkg::*;
#(
  parameter int                  ID_BITS   = 44,
  parameter int                  GROUP     = 4,
  parameter int                  FAST_DIV  = 8,
  parameter int                  FAST_HIGH = 2,
  parameter int                  FAST_REPS = 6,
  parameter int                  SLOW_DIV  = 10,
  parameter int                  SLOW_HIGH = 3,
  parameter int                  SLOW_REPS = 5,
  parameter int                  SEP_REPS  = 1,
  parameter int                  MARK_LEN  = 8,
  parameter logic [MARK_LEN-1:0] MARK_PAT  = 8'b1011_1000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               enable,
  input  logic [ID_BITS-1:0] tag_id,
  output logic               coil_out,
  output logic               frame_start
);

  localparam int N_SLOW_MARK = $countones(MARK_PAT);
  localparam int N_FAST_MARK = MARK_LEN - N_SLOW_MARK;
  localparam int FAST_HALF   = FAST_DIV * FAST_REPS;
  localparam int SLOW_HALF   = SLOW_DIV * SLOW_REPS;
  localparam int FRAME_LEN   = N_SLOW_MARK * SLOW_HALF + N_FAST_MARK * FAST_HALF
                             + ID_BITS * (FAST_HALF + SLOW_HALF)
                             + (ID_BITS / GROUP) * SEP_REPS * FAST_DIV;

  seg_t               seg;
  logic               level;
  logic               seg_first;
  logic               seg_last;
  logic               at_head;
  logic [ID_BITS-1:0] id_q;

  fsk_frame_seq #(
    .ID_BITS (ID_BITS),
    .GROUP   (GROUP),
    .MARK_LEN(MARK_LEN),
    .MARK_PAT(MARK_PAT)
  ) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (enable),
    .seg_last(seg_last),
    .id_bits (id_q),
    .seg     (seg),
    .at_head (at_head)
  );

  fsk_burst #(
    .FAST_DIV (FAST_DIV),
    .FAST_HIGH(FAST_HIGH),
    .FAST_REPS(FAST_REPS),
    .SLOW_DIV (SLOW_DIV),
    .SLOW_HIGH(SLOW_HIGH),
    .SLOW_REPS(SLOW_REPS),
    .SEP_REPS (SEP_REPS)
  ) u_burst (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (enable),
    .seg      (seg),
    .level    (level),
    .seg_first(seg_first),
    .seg_last (seg_last)
  );

  assign frame_start = enable && at_head && seg_first;
  assign coil_out    = enable && level;

  // Identifier is held for the whole frame; data halves start long after tick 0.
  always_ff @(posedge clk) begin
    if (!rst_n)
      id_q <= '0;
    else if (frame_start)
      id_q <= tag_id;
  end

endmodule

// File: rtl/fsk_tag_wavegen_chk.sv
module fsk_tag_wavegen_chk #(
  parameter int FRAME_LEN = 4792,
  parameter int FAST_DIV  = 8,
  parameter int SLOW_DIV  = 10,
  parameter int MAX_HIGH  = 3
) (
  input logic clk,
  input logic rst_n,
  input logic enable,
  input logic coil_out,
  input logic frame_start
);

  int   frm_cnt;
  logic frm_seen;
  int   gap_cnt;
  logic gap_seen;
  logic prev_out;
  int   hi_run;
  logic rise;

  assign rise = coil_out && !prev_out;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      frm_cnt  <= 0;
      frm_seen <= 1'b0;
      gap_cnt  <= 0;
      gap_seen <= 1'b0;
      prev_out <= 1'b0;
      hi_run   <= 0;
    end else begin
      prev_out <= coil_out;
      hi_run   <= coil_out ? hi_run + 1 : 0;
      if (!enable) begin
        frm_seen <= 1'b0;
        gap_seen <= 1'b0;
      end else begin
        if (frame_start) begin
          frm_seen <= 1'b1;
          frm_cnt  <= 1;
        end else begin
          frm_cnt <= frm_cnt + 1;
        end
        if (rise) begin
          gap_seen <= 1'b1;
          gap_cnt  <= 1;
        end else begin
          gap_cnt <= gap_cnt + 1;
        end
      end
    end
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |-> (!coil_out && !frame_start)); // R1

  AST_START_ON_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(enable) |-> frame_start); // R8

  AST_FRAME_NOT_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_start && frm_seen) |-> (frm_cnt == FRAME_LEN)); // R7

  AST_FRAME_NOT_LATE: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && frm_seen && frm_cnt == FRAME_LEN) |-> frame_start); // R7

  AST_RISE_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && rise && gap_seen) |-> (gap_cnt == FAST_DIV || gap_cnt == SLOW_DIV)); // R2

  AST_HIGH_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    coil_out |-> (hi_run < MAX_HIGH)); // R3

endmodule

bind fsk_tag_wavegen fsk_tag_wavegen_chk #(
  .FRAME_LEN(FRAME_LEN),
  .FAST_DIV (FAST_DIV),
  .SLOW_DIV (SLOW_DIV),
  .MAX_HIGH ((SLOW_HIGH > FAST_HIGH) ? SLOW_HIGH : FAST_HIGH)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .enable     (enable),
  .coil_out   (coil_out),
  .frame_start(frame_start)
);

// File: tb/test_fsk_tag_wavegen.sv
`timescale 1ns/1ps
module test_fsk_tag_wavegen;

  localparam int IDW   = 44;
  localparam int FRAME = 4792;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           enable = 1'b0;
  logic [IDW-1:0] tag_id = '0;
  logic           coil_out;
  logic           frame_start;

  int checks = 0;
  int errors = 0;
  int ones_fast;
  int ones_slow;

  always #2.5 clk = ~clk;

  fsk_tag_wavegen i_fsk_tag_wavegen (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (enable),
    .tag_id     (tag_id),
    .coil_out   (coil_out),
    .frame_start(frame_start)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp,
                       input string what);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int pat(input bit slow, input int off);
    return slow ? int'((off % 10) < 3) : int'((off % 8) < 2);
  endfunction

  // Returns expected bit in bit 0 and region in bits 2:1 (1 marker, 2 separator, 3 data).
  function automatic int exp_tick(input logic [IDW-1:0] v, input int t);
    bit [7:0] mk = 8'b1011_1000;  // marker order fast,fast,fast,slow,slow,slow,fast,slow
    int pos = 0;
    for (int m = 0; m < 8; m++) begin
      int len = mk[m] ? 50 : 48;
      if (t < pos + len) return 2 | pat(mk[m], t - pos);
      pos += len;
    end
    for (int b = IDW - 1; b >= 0; b--) begin
      if ((b % 4) == 3) begin
        if (t < pos + 8) return 4 | pat(1'b0, t - pos);
        pos += 8;
      end
      for (int h = 0; h < 2; h++) begin
        bit slow = (h == 0) ? !v[b] : v[b];
        int len  = slow ? 50 : 48;
        if (t < pos + len) return 6 | pat(slow, t - pos);
        pos += len;
      end
    end
    return -1;
  endfunction

  task automatic run_frame(input logic [IDW-1:0] expv, input logic [IDW-1:0] nextv,
                           input int nticks, input string force_tag);
    ones_fast = 0;
    ones_slow = 0;
    for (int t = 0; t < nticks; t++) begin
      int    r;
      int    rg;
      string tg;
      @(negedge clk);
      r  = exp_tick(expv, t);
      rg = r >> 1;
      if (force_tag != "")          tg = force_tag;
      else if (rg == 1)             tg = "R4";
      else if (rg == 2)             tg = "R6";
      else if (tag_id !== expv)     tg = "R9";
      else                          tg = "R5";
      check(coil_out === r[0], tg, int'(coil_out), r & 1, $sformatf("coil tick %0d", t));
      check(frame_start === (t == 0), (t == 0) ? "R7" : "R8", int'(frame_start),
            int'(t == 0), $sformatf("frame_start tick %0d", t));
      if (t >= 400 && t < 448 && coil_out) ones_fast++;
      if (t >= 448 && t < 498 && coil_out) ones_slow++;
      if (t == 2000) tag_id = nextv;
    end
  endtask

  logic [IDW-1:0] ids [8];

  initial begin
    ids[0] = 44'hFFF_FFFF_FFFF;
    ids[1] = 44'h000_0000_0000;
    ids[2] = 44'hAAA_AAAA_AAAA;
    ids[3] = 44'h555_5555_5555;
    ids[4] = 44'h123_4567_89AB;
    ids[5] = 44'h800_0000_0001;
    ids[6] = 44'hF0F_0F0F_0F0F;
    ids[7] = 44'h0F1_E2D3_C4B5;

    repeat (4) begin
      @(negedge clk);
      check(coil_out === 1'b0 && frame_start === 1'b0, "R1", int'(coil_out),
            0, "outputs in reset");
    end
    rst_n  = 1'b1;
    tag_id = 44'h3C3_3C3C_3C3C;
    repeat (6) begin
      @(negedge clk);
      check(coil_out === 1'b0, "R1", int'(coil_out), 0, "coil while disabled");
      check(frame_start === 1'b0, "R1", int'(frame_start), 0, "frame_start while disabled");
    end

    tag_id = ids[0];
    @(posedge clk);
    #1 enable = 1'b1;
    for (int k = 0; k < 8; k++) begin
      run_frame(ids[k], (k < 7) ? ids[k + 1] : 44'hC3C_3C3C_3C3C, FRAME, "");
      if (k == 0) begin
        check(ones_fast == 12, "R2", ones_fast, 12, "ones in fast half-bit");
        check(ones_slow == 15, "R3", ones_slow, 15, "ones in slow half-bit");
      end
    end

    // Abort mid-frame, idle, then restart from the marker.
    run_frame(44'hC3C_3C3C_3C3C, 44'hC3C_3C3C_3C3C, 700, "");
    @(posedge clk);
    #1 enable = 1'b0;
    repeat (20) begin
      @(negedge clk);
      check(coil_out === 1'b0, "R1", int'(coil_out), 0, "coil after disable");
      check(frame_start === 1'b0, "R1", int'(frame_start), 0, "frame_start after disable");
    end
    tag_id = 44'h6B2_E91F_0C47;
    @(posedge clk);
    #1 enable = 1'b1;
    run_frame(44'h6B2_E91F_0C47, 44'h6B2_E91F_0C47, FRAME, "R10");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule